// File: doc/BRIEF.md
# Strided Vector Address Generator

This block turns one vector memory command into the eight linear element addresses that a parallel-module memory needs, all produced in the same cycle. The addresses follow base + i·step for lanes i = 0..7. The step, and the stride-family code that the downstream address translation stage uses to pick its internal layout, both come from a stride register. Software loads that register with the size of the structure being walked.

Each command selects one of three flavours. The strided flavour walks one field across consecutive structures. The unit-stride flavour walks consecutive words but keeps the family code of the stride register, so a row of data laid out for column access can be read in one go. The plain flavour produces aligned unit-stride addresses marked as non-strided, so downstream logic can bypass its permutation. Bases may be unaligned in the first two flavours. Stores carry a per-element write mask. All outputs are registered and come with a one-cycle valid strobe.

Top module: `svag_top`

## Requirements
- R1: A request sampled on a clock edge makes `valid_o` high for exactly the following cycle, unless R5 applies. With no request, `valid_o` is low.
- R2: With `use_stride_i`=1 (this takes priority over `use_family_i`), lane i's address is base + i·stride, `fam_o` is the index of the lowest set bit of the stride register, and `nas_o`=0.
- R3: With `use_stride_i`=0 and `use_family_i`=1, lane i's address is base + i, `fam_o` is the index of the lowest set bit of the stride register, and `nas_o`=0.
- R4: With both flags 0, lane i's address is (base with its low 3 bits cleared) + i, `fam_o`=0 and `nas_o`=1. The stride register value has no effect, including zero.
- R5: A request in the R2 or R3 flavour while the stride register holds zero makes `illegal_o` high for the next cycle. `valid_o` stays low in that cycle, and the address, family, flag and mask outputs keep their previous values.
- R6: `set_stride_i` loads `stride_val_i` into the stride register at the clock edge. A request in the same cycle uses the old value. After reset the register holds 1.
- R7: On a valid result, bit i of `wmask_o` equals bit i of `mask_i` when `we_i`=1 (lane i is written), and `wmask_o` is 0 when `we_i`=0.
- R8: Addresses are computed modulo 2^ADDR_W (16 bits by default). Lane i is packed at `addr_o[i*16 +: 16]`.
- R9: During and after reset, `valid_o`, `illegal_o`, `nas_o`, `fam_o`, `wmask_o` and `addr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| set_stride_i | input | 1 | Load the stride register |
| stride_val_i | input | STRIDE_W (8) | Value for the stride register |
| req_i | input | 1 | Vector access command |
| base_i | input | ADDR_W (16) | Element base address |
| use_stride_i | input | 1 | Strided flavour |
| use_family_i | input | 1 | Unit stride keeping the register's family |
| we_i | input | 1 | Command is a store |
| mask_i | input | LANES (8) | Per-lane store enable |
| valid_o | output | 1 | Address set valid this cycle |
| illegal_o | output | 1 | Rejected command (zero stride) |
| addr_o | output | LANES*ADDR_W (128) | Packed lane addresses |
| fam_o | output | FAM_W (3) | Stride family code |
| nas_o | output | 1 | Non-strided aligned pattern |
| wmask_o | output | LANES (8) | Per-lane write mask |

## Verification
The checker assumes that the inputs are clean and stable around each rising edge. It tracks only the flavour and the store flag of the most recent request, so it assumes nothing about how far apart requests are. The stimulus drives every input on the falling edge and holds it for a full cycle. Directed stimulus covers each flavour, zero and even strides, wrap at the top of the address space, and a stride load in the same cycle as a request. A random phase then mixes back-to-back and idle cycles with all flag combinations.

// File: rtl/svag_pkg.sv
package svag_pkg;
  typedef enum logic [1:0] {
    MODE_NAS     = 2'd0,
    MODE_UNITFAM = 2'd1,
    MODE_STRIDED = 2'd2
  } mode_e;

  // index of lowest set bit; 0 for a zero input
  function automatic logic [4:0] low_bit_idx(input logic [31:0] v);
    logic [4:0] r;
    r = '0;
    for (int k = 31; k >= 0; k--) begin
      if (v[k]) r = 5'(k);
    end
    return r;
  endfunction
endpackage

// File: rtl/svag_stride_reg.sv
module svag_stride_reg #(
  parameter int STRIDE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [STRIDE_W-1:0] val_i,
  output logic [STRIDE_W-1:0] stride_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stride_o <= STRIDE_W'(1);
    else if (load_i) stride_o <= val_i;
  end
endmodule

// File: rtl/svag_mode_dec.sv
module svag_mode_dec
  import svag_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int STRIDE_W = 8,
  parameter int LANE_LOG = 3,
  parameter int FAM_W    = 3
) (
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic                use_stride_i,
  input  logic                use_family_i,
  output logic [ADDR_W-1:0]   start_o,
  output logic [ADDR_W-1:0]   step_o,
  output logic [FAM_W-1:0]    fam_o,
  output logic                nas_o,
  output logic                illegal_o
);
  mode_e             mode;
  logic [FAM_W-1:0]  fam_reg;
  logic [4:0]        low_idx;

  assign low_idx = low_bit_idx(32'(stride_i));
  assign fam_reg = low_idx[FAM_W-1:0];

  always_comb begin
    if (use_stride_i)      mode = MODE_STRIDED;
    else if (use_family_i) mode = MODE_UNITFAM;
    else                   mode = MODE_NAS;
  end

  always_comb begin
    start_o   = base_i;
    step_o    = ADDR_W'(1);
    fam_o     = fam_reg;
    nas_o     = 1'b0;
    illegal_o = 1'b0;
    unique case (mode)
      MODE_STRIDED: begin
        step_o    = ADDR_W'(stride_i);
        illegal_o = (stride_i == '0);
      end
      MODE_UNITFAM: illegal_o = (stride_i == '0);
      default: begin
        start_o = {base_i[ADDR_W-1:LANE_LOG], {LANE_LOG{1'b0}}};
        fam_o   = '0;
        nas_o   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/svag_lane_gen.sv
module svag_lane_gen #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 8
) (
  input  logic [ADDR_W-1:0]       start_i,
  input  logic [ADDR_W-1:0]       step_i,
  output logic [LANES*ADDR_W-1:0] addr_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ADDR_W-1:0] ofs;
    assign ofs = ADDR_W'(step_i * ADDR_W'(g));
    assign addr_o[g*ADDR_W +: ADDR_W] = start_i + ofs;
  end
endmodule

// File: rtl/svag_top.sv
module svag_top #(
  parameter int ADDR_W   = 16,
  parameter int STRIDE_W = 8,
  parameter int LANES    = 8,
  parameter int LANE_LOG = $clog2(LANES),
  parameter int FAM_W    = $clog2(STRIDE_W)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    set_stride_i,
  input  logic [STRIDE_W-1:0]     stride_val_i,
  input  logic                    req_i,
  input  logic [ADDR_W-1:0]       base_i,
  input  logic                    use_stride_i,
  input  logic                    use_family_i,
  input  logic                    we_i,
  input  logic [LANES-1:0]        mask_i,
  output logic                    valid_o,
  output logic                    illegal_o,
  output logic [LANES*ADDR_W-1:0] addr_o,
  output logic [FAM_W-1:0]        fam_o,
  output logic                    nas_o,
  output logic [LANES-1:0]        wmask_o
);
  logic [STRIDE_W-1:0]     stride_q;
  logic [ADDR_W-1:0]       start_d, step_d;
  logic [FAM_W-1:0]        fam_d;
  logic                    nas_d, bad_d;
  logic [LANES*ADDR_W-1:0] addr_d;
  logic                    accept;

  svag_stride_reg #(.STRIDE_W(STRIDE_W)) stride_reg_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (set_stride_i),
    .val_i   (stride_val_i),
    .stride_o(stride_q)
  );

  svag_mode_dec #(
    .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .LANE_LOG(LANE_LOG), .FAM_W(FAM_W)
  ) mode_dec_i (
    .base_i      (base_i),
    .stride_i    (stride_q),
    .use_stride_i(use_stride_i),
    .use_family_i(use_family_i),
    .start_o     (start_d),
    .step_o      (step_d),
    .fam_o       (fam_d),
    .nas_o       (nas_d),
    .illegal_o   (bad_d)
  );

  svag_lane_gen #(.ADDR_W(ADDR_W), .LANES(LANES)) lane_gen_i (
    .start_i(start_d),
    .step_i (step_d),
    .addr_o (addr_d)
  );

  assign accept = req_i && !bad_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      valid_o   <= accept;
      illegal_o <= req_i && bad_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      fam_o   <= '0;
      nas_o   <= 1'b0;
      wmask_o <= '0;
    end else if (accept) begin
      addr_o  <= addr_d;
      fam_o   <= fam_d;
      nas_o   <= nas_d;
      wmask_o <= we_i ? mask_i : '0;
    end
  end
endmodule

// File: rtl/svag_chk.sv
module svag_chk #(
  parameter int ADDR_W   = 16,
  parameter int STRIDE_W = 8,
  parameter int LANES    = 8,
  parameter int LANE_LOG = 3,
  parameter int FAM_W    = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    set_stride_i,
  input logic [STRIDE_W-1:0]     stride_val_i,
  input logic                    req_i,
  input logic [ADDR_W-1:0]       base_i,
  input logic                    use_stride_i,
  input logic                    use_family_i,
  input logic                    we_i,
  input logic [LANES-1:0]        mask_i,
  input logic                    valid_o,
  input logic                    illegal_o,
  input logic [LANES*ADDR_W-1:0] addr_o,
  input logic [FAM_W-1:0]        fam_o,
  input logic                    nas_o,
  input logic [LANES-1:0]        wmask_o
);
  logic req_q, strided_q, we_q;
  logic [ADDR_W-1:0] lane_gap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q     <= 1'b0;
      strided_q <= 1'b0;
      we_q      <= 1'b0;
    end else begin
      req_q <= req_i;
      if (req_i) begin
        strided_q <= use_stride_i;
        we_q      <= we_i;
      end
    end
  end

  assign lane_gap = addr_o[2*ADDR_W-1:ADDR_W] - addr_o[ADDR_W-1:0];

  AST_RESULT_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o || illegal_o) == req_q); // R1
  AST_VALID_ILLEGAL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && illegal_o)); // R5
  AST_NAS_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && nas_o) |-> (addr_o[LANE_LOG-1:0] == '0 && fam_o == '0)); // R4
  AST_UNIT_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !strided_q) |-> (lane_gap == ADDR_W'(1))); // R3
  AST_READ_NO_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !we_q) |-> (wmask_o == '0)); // R7
  AST_ILLEGAL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ($stable(addr_o) && $stable(wmask_o) && $stable(fam_o))); // R5
endmodule

bind svag_top svag_chk #(
  .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .LANES(LANES), .LANE_LOG(LANE_LOG), .FAM_W(FAM_W)
) chk_i (.*);

// File: tb/svag_top_tb_top.sv
module svag_top_tb_top;
  localparam int AW = 16;
  localparam int SW = 8;
  localparam int NL = 8;
  localparam int FW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_stride = 1'b0;
  logic [SW-1:0] stride_val = '0;
  logic req = 1'b0;
  logic [AW-1:0] base = '0;
  logic use_stride = 1'b0, use_family = 1'b0, we = 1'b0;
  logic [NL-1:0] mask = '0;
  logic valid, illegal, nas;
  logic [NL*AW-1:0] addr;
  logic [FW-1:0] fam;
  logic [NL-1:0] wmask;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  svag_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .set_stride_i(set_stride), .stride_val_i(stride_val),
    .req_i(req), .base_i(base), .use_stride_i(use_stride), .use_family_i(use_family),
    .we_i(we), .mask_i(mask), .valid_o(valid), .illegal_o(illegal), .addr_o(addr),
    .fam_o(fam), .nas_o(nas), .wmask_o(wmask)
  );

  always #5 clk = ~clk;

  // behavioural reference
  int m_stride = 1;
  bit e_valid = 0, e_ill = 0, e_nas = 0;
  int e_fam = 0;
  int e_addr[NL];
  int e_mask = 0;
  string e_tag = "R9";

  function automatic int lowbit(int v);
    for (int k = 0; k < 32; k++) if (v[k]) return k;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stride = 1; e_valid = 0; e_ill = 0; e_nas = 0; e_fam = 0; e_mask = 0;
      foreach (e_addr[k]) e_addr[k] = 0;
      e_tag = "R9";
    end else begin
      e_valid = 0; e_ill = 0;
      if (req) begin
        int st, b;
        bit nasf;
        nasf = !use_stride && !use_family;
        if (!nasf && m_stride == 0) e_ill = 1;
        else begin
          e_valid = 1;
          b = base;
          if (use_stride) begin st = m_stride; e_tag = "R2"; end
          else if (use_family) begin st = 1; e_tag = "R3"; end
          else begin st = 1; b = b & ~7; e_tag = "R4"; end
          for (int k = 0; k < NL; k++) e_addr[k] = (b + k * st) % 65536;
          e_nas = nasf;
          e_fam = nasf ? 0 : lowbit(m_stride) % 8;
          e_mask = we ? int'(mask) : 0;
        end
      end
      if (set_stride) m_stride = stride_val;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(valid == e_valid, "R1", valid, e_valid);
      chk(illegal == e_ill, "R5", illegal, e_ill);
      if (e_valid) begin
        for (int k = 0; k < NL; k++)
          chk(int'(addr[k*AW +: AW]) == e_addr[k], {e_tag, "/R8 addr"}, addr[k*AW +: AW], e_addr[k]);
        chk(int'(fam) == e_fam, {e_tag, " fam"}, fam, e_fam);
        chk(nas == e_nas, "R4 nas", nas, e_nas);
        chk(int'(wmask) == e_mask, "R7", wmask, e_mask);
      end
    end
  end

  task automatic issue(input int b, input bit us, input bit uf, input bit w, input int m);
    @(negedge clk);
    req = 1; base = AW'(b); use_stride = us; use_family = uf; we = w; mask = NL'(m);
    @(negedge clk);
    req = 0; we = 0; mask = '0;
  endtask

  task automatic load(input int s);
    @(negedge clk);
    set_stride = 1; stride_val = SW'(s);
    @(negedge clk);
    set_stride = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(valid == 0 && illegal == 0 && nas == 0 && fam == 0 && wmask == 0 && addr == '0,
        "R9", {valid, illegal}, 0);
    rst_n = 1'b1;
    issue(16'h0103, 1, 0, 0, 0);       // R6 reset stride 1
    load(4);
    issue(16'h0011, 1, 0, 1, 8'h0F);   // R2 unaligned, R7 mask
    issue(16'h0011, 0, 1, 1, 8'h03);   // R3 family keeps s=2
    issue(16'h0011, 0, 0, 0, 8'hFF);   // R4 aligned, read mask zero
    issue(16'h0015, 1, 1, 1, 8'h01);   // R2 priority
    load(6);
    issue(16'hFFF0, 1, 0, 1, 8'hAA);   // R8 wrap, s=1
    load(0);
    issue(16'h0200, 1, 0, 1, 8'hFF);   // R5
    issue(16'h0200, 0, 1, 0, 0);       // R5
    issue(16'hFFFD, 0, 0, 1, 8'h80);   // R4 zero stride ignored
    // R6 same-cycle load and request uses old value
    @(negedge clk);
    set_stride = 1; stride_val = 8'd32; req = 1; base = 16'h0040; use_stride = 1; use_family = 0;
    @(negedge clk);
    set_stride = 0; req = 0;
    issue(16'h0040, 1, 0, 0, 0);
    // random phase, back-to-back
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      req = $urandom_range(0, 3) != 0;
      base = AW'($urandom);
      use_stride = 1'($urandom); use_family = 1'($urandom);
      we = 1'($urandom); mask = NL'($urandom);
      set_stride = $urandom_range(0, 5) == 0;
      stride_val = ($urandom_range(0, 7) == 0) ? '0 : SW'($urandom);
    end
    @(negedge clk);
    req = 0; set_stride = 0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule